// File: doc/BRIEF.md
# Double-Buffered Interrupt Status Register

This block holds the status a receiver decoder presents to a host. The host reads a primary status word. The block raises an interrupt line whenever that word holds content the host has not yet read. A second, pending word catches events that arrive while the primary is still unread, or while the host is in the middle of a read. When the read finishes, the pending word moves into the primary. The interrupt line then drops for one clock and rises again, so an edge-sensitive host sees a fresh request.

The block also keeps an out-of-range flag. Fade recovery or carrier loss sets the flag, and detection of preamble or a valid sync word clears it. The flag becomes visible in the status word only when the receiver enable falls. Each change of the visible flag is an interrupt event in its own right. The read protocol of the host bus and the decoding of calls sit outside this block; it sees only strobes.

Top module: `dbl_int_status`

## Requirements
- R1: While reset is held and after its release, status_o reads all zero and int_o is low.
- R2: A call strobe arrives when the primary holds no unread content and no read is in progress. From the next cycle, status_o shows the call bits and int_o is high. Bit position OOR_BIT of call_status_i is ignored.
- R3: A read is in progress from the cycle after rd_start_i through the cycle of rd_end_i. An event that arrives while the primary is unread, or while a read is in progress, leaves status_o unchanged and goes into the pending word.
- R4: rd_end_i is sampled while content is pending. In the next cycle status_o shows the pending content and int_o is low. In the cycle after that, int_o is high.
- R5: When several calls arrive while the primary is unread, only the bits of the most recent call reach status_o after the read.
- R6: rd_end_i is sampled with nothing pending and no event in the same cycle. int_o then goes low and stays low until a new event arrives.
- R7: An internal out-of-range flag is set by fade_i and cleared by preamble_i or sync_i. If both arrive in the same cycle, fade_i wins.
- R8: status_o bit OOR_BIT takes the internal flag's value only in the cycle after rx_en_i goes from 1 to 0. At all other times it holds its value.
- R9: A change of status_o bit OOR_BIT is an interrupt event with no call bits. It is routed by the rules of R2/R3. When it lands in the primary, it clears the call bits there. When it lands in the pending word, it keeps the pending call bits.
- R10: An event in the same cycle as rd_end_i is treated as pending content. It is reloaded into the primary at once, and its call bits win over older pending bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Decoder clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| call_valid_i | input | 1 | Call event strobe |
| call_status_i | input | STAT_W | Status bits of the call |
| fade_i | input | 1 | Entry into fade recovery or carrier-off |
| preamble_i | input | 1 | Preamble detected |
| sync_i | input | 1 | Valid sync word detected |
| rx_en_i | input | 1 | Receiver enable |
| rd_start_i | input | 1 | Host status read begins |
| rd_end_i | input | 1 | Host status read completes |
| status_o | output | STAT_W | Primary status word |
| int_o | output | 1 | Interrupt request, active high |

## Verification
The bench builds the block with its defaults: an 8-bit status word with the out-of-range flag at bit 5. This places the flag inside the word, so the masking of that call bit and the pending-preserving flag event can both be seen at status_o. Random traffic makes reads overlap with calls and receiver toggles. It reaches collisions that directed tests alone would miss, such as a flag change landing on the closing cycle of a read or during the one-cycle interrupt gap.

// File: rtl/dis_pkg.sv
package dis_pkg;
  localparam int unsigned STAT_W_DEF  = 8;
  localparam int unsigned OOR_POS_DEF = 5;

  typedef enum logic [1:0] {
    DST_NONE = 2'd0,
    DST_PRIM = 2'd1,
    DST_PEND = 2'd2
  } evt_dst_e;
endpackage

// File: rtl/dis_oor_track.sv
module dis_oor_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fade_i,
  input  logic preamble_i,
  input  logic sync_i,
  input  logic rx_en_i,
  output logic oor_vis_o,
  output logic chg_o
);
  logic oor_q, vis_q, rx_en_q, fall;

  assign fall = rx_en_q & ~rx_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oor_q   <= 1'b0;
      vis_q   <= 1'b0;
      rx_en_q <= 1'b0;
    end else begin
      rx_en_q <= rx_en_i;
      if (fade_i)                   oor_q <= 1'b1;
      else if (preamble_i || sync_i) oor_q <= 1'b0;
      if (fall) vis_q <= oor_q;
    end
  end

  assign oor_vis_o = vis_q;
  assign chg_o     = fall & (oor_q ^ vis_q);

  p_fade_sets_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fade_i |=> oor_q);
  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fade_i && (preamble_i || sync_i)) |=> !oor_q);
  p_vis_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fall |=> $stable(vis_q));
  p_chg_flips_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_o |=> (vis_q != $past(vis_q)));
endmodule

// File: rtl/dis_pend_buf.sv
module dis_pend_buf #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         evt_valid_i,
  input  logic         evt_call_i,
  input  logic [W-1:0] evt_bits_i,
  input  logic         hold_i,
  input  logic         take_i,
  output logic         pend_valid_o,
  output logic [W-1:0] pend_bits_o
);
  logic         valid_q;
  logic [W-1:0] bits_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      bits_q  <= '0;
    end else if (take_i) begin
      valid_q <= 1'b0;
      bits_q  <= '0;
    end else if (evt_valid_i && hold_i) begin
      valid_q <= 1'b1;
      if (evt_call_i) bits_q <= evt_bits_i;  // last call wins
    end
  end

  assign pend_valid_o = valid_q;
  assign pend_bits_o  = bits_q;

  p_last_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && evt_call_i && hold_i && !take_i) |=> (bits_q == $past(evt_bits_i)));
  p_flag_keeps_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && !evt_call_i && hold_i && !take_i) |=> ($stable(bits_q) && valid_q));
  p_take_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> !valid_q);
endmodule

// File: rtl/dis_prim_reg.sv
module dis_prim_reg
  import dis_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         evt_valid_i,
  input  logic         evt_call_i,
  input  logic [W-1:0] evt_bits_i,
  input  logic         rd_start_i,
  input  logic         rd_end_i,
  input  logic         pend_valid_i,
  input  logic [W-1:0] pend_bits_i,
  output logic         hold_o,
  output logic [W-1:0] prim_o,
  output logic         int_o
);
  logic         busy_q, unread_q, gap_q;
  logic [W-1:0] prim_q, reload_bits;
  evt_dst_e     dst;
  logic         reload;

  assign hold_o = unread_q | busy_q;
  assign reload = rd_end_i & (pend_valid_i | evt_valid_i);

  always_comb begin
    if (evt_call_i && evt_valid_i) reload_bits = evt_bits_i;
    else if (pend_valid_i)         reload_bits = pend_bits_i;
    else                           reload_bits = '0;
  end

  always_comb begin
    if (!evt_valid_i || rd_end_i) dst = DST_NONE;
    else if (hold_o)              dst = DST_PEND;
    else                          dst = DST_PRIM;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      unread_q <= 1'b0;
      gap_q    <= 1'b0;
      prim_q   <= '0;
    end else begin
      if (rd_end_i)        busy_q <= 1'b0;
      else if (rd_start_i) busy_q <= 1'b1;

      if (rd_end_i) begin
        unread_q <= reload;
        gap_q    <= reload;
        if (reload) prim_q <= reload_bits;
      end else begin
        gap_q <= 1'b0;
        if (dst == DST_PRIM) begin
          unread_q <= 1'b1;
          prim_q   <= evt_call_i ? evt_bits_i : '0;
        end
      end
    end
  end

  assign prim_o = prim_q;
  assign int_o  = unread_q & ~gap_q;

  p_idle_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && !hold_o && !rd_end_i) |=> int_o);
  p_hold_prim_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && hold_o && !rd_end_i) |=> $stable(prim_q));
  p_gap_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload |=> !int_o);
  p_rearm_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gap_q && !rd_end_i) |=> int_o);
  p_empty_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_end_i && !reload) |=> !int_o);
  p_quiet_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!int_o && !gap_q && !evt_valid_i) |=> !int_o);
endmodule

// File: rtl/dbl_int_status.sv
module dbl_int_status
  import dis_pkg::*;
#(
  parameter int unsigned STAT_W  = STAT_W_DEF,
  parameter int unsigned OOR_BIT = OOR_POS_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              call_valid_i,
  input  logic [STAT_W-1:0] call_status_i,
  input  logic              fade_i,
  input  logic              preamble_i,
  input  logic              sync_i,
  input  logic              rx_en_i,
  input  logic              rd_start_i,
  input  logic              rd_end_i,
  output logic [STAT_W-1:0] status_o,
  output logic              int_o
);
  logic              oor_vis, oor_chg, evt_valid, hold, pend_valid;
  logic [STAT_W-1:0] evt_bits, pend_bits, prim;

  assign evt_valid = call_valid_i | oor_chg;

  for (genvar i = 0; i < STAT_W; i++) begin : g_bit
    if (i == OOR_BIT) begin : g_flag
      assign evt_bits[i] = 1'b0;
      assign status_o[i] = oor_vis;
    end else begin : g_call
      assign evt_bits[i] = call_status_i[i];
      assign status_o[i] = prim[i];
    end
  end

  dis_oor_track u_oor (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fade_i     (fade_i),
    .preamble_i (preamble_i),
    .sync_i     (sync_i),
    .rx_en_i    (rx_en_i),
    .oor_vis_o  (oor_vis),
    .chg_o      (oor_chg)
  );

  dis_pend_buf #(.W(STAT_W)) u_pend (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .evt_valid_i  (evt_valid),
    .evt_call_i   (call_valid_i),
    .evt_bits_i   (evt_bits),
    .hold_i       (hold),
    .take_i       (rd_end_i),
    .pend_valid_o (pend_valid),
    .pend_bits_o  (pend_bits)
  );

  dis_prim_reg #(.W(STAT_W)) u_prim (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .evt_valid_i  (evt_valid),
    .evt_call_i   (call_valid_i),
    .evt_bits_i   (evt_bits),
    .rd_start_i   (rd_start_i),
    .rd_end_i     (rd_end_i),
    .pend_valid_i (pend_valid),
    .pend_bits_i  (pend_bits),
    .hold_o       (hold),
    .prim_o       (prim),
    .int_o        (int_o)
  );

  p_reset_r1: assert property (@(posedge clk_i)
    !rst_ni |=> (status_o == '0 && !int_o));
  p_flag_event_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oor_chg && !hold && !rd_end_i && !call_valid_i) |=>
      (int_o && status_o == (STAT_W'(1) << OOR_BIT) * STAT_W'(status_o[OOR_BIT])));
endmodule

// File: tb/test_dbl_int_status.sv
module test_dbl_int_status;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int OB = 5;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic call_valid_i = 0, fade_i = 0, preamble_i = 0, sync_i = 0;
  logic rx_en_i = 0, rd_start_i = 0, rd_end_i = 0;
  logic [W-1:0] call_status_i = '0, status_o;
  logic int_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  // reference state
  logic [W-1:0] m_prim = '0, m_pend = '0;
  logic m_pv = 0, m_unread = 0, m_gap = 0, m_busy = 0;
  logic m_oor = 0, m_vis = 0, m_rxq = 0;

  dbl_int_status i_dbl_int_status (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;
  always @(posedge clk_i) cyc++;

  function automatic logic [W-1:0] exp_status();
    logic [W-1:0] s = m_prim;
    s[OB] = m_vis;
    return s;
  endfunction

  function automatic logic exp_int();
    return m_unread & ~m_gap;
  endfunction

  // advance the reference by one clock with the current inputs
  function automatic void model_step();
    logic fall, chg, ev, hold, rel;
    logic [W-1:0] cb, rb;
    fall = m_rxq & ~rx_en_i;
    chg  = fall & (m_oor ^ m_vis);
    ev   = call_valid_i | chg;
    cb   = call_status_i; cb[OB] = 1'b0;
    hold = m_unread | m_busy;
    rel  = rd_end_i & (m_pv | ev);
    rb   = call_valid_i ? cb : (m_pv ? m_pend : '0);
    if (rd_end_i) begin
      m_unread = rel; m_gap = rel;
      if (rel) m_prim = rb;
      m_pv = 0; m_pend = '0;
    end else begin
      m_gap = 0;
      if (ev && !hold) begin
        m_unread = 1; m_prim = call_valid_i ? cb : '0;
      end else if (ev) begin
        m_pv = 1; if (call_valid_i) m_pend = cb;
      end
    end
    if (rd_end_i) m_busy = 0; else if (rd_start_i) m_busy = 1;
    if (fall) m_vis = m_oor;
    if (fade_i) m_oor = 1; else if (preamble_i || sync_i) m_oor = 0;
    m_rxq = rx_en_i;
  endfunction

  task automatic check(string tag);
    n_chk++;
    if (status_o !== exp_status() || int_o !== exp_int()) begin
      n_fail++;
      $display("FAIL %s cyc %0d status act %h exp %h int act %b exp %b",
               tag, cyc, status_o, exp_status(), int_o, exp_int());
    end
  endtask

  task automatic clear_in();
    call_valid_i = 0; fade_i = 0; preamble_i = 0; sync_i = 0;
    rd_start_i = 0; rd_end_i = 0;
  endtask

  // inputs set at negedge; one edge later, compare at negedge
  task automatic cyc1(string tag);
    model_step();
    @(negedge clk_i);
    check(tag);
    clear_in();
  endtask

  task automatic call(logic [W-1:0] b, string tag);
    call_valid_i = 1; call_status_i = b; cyc1(tag);
  endtask

  task automatic read(string tag);
    rd_start_i = 1; cyc1(tag);
    rd_end_i = 1;   cyc1(tag);
    cyc1(tag);
    cyc1(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk_i);
    n_chk++;
    if (status_o !== '0 || int_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 in reset status act %h exp 00 int act %b exp 0", status_o, int_o);
    end
    rst_ni = 1;
    @(negedge clk_i); check("R1");

    // idle call, masked flag bit
    call(8'hFF, "R2");
    cyc1("R2");
    // calls while unread: primary holds, last wins
    call(8'h11, "R3");
    call(8'h42, "R5");
    call(8'h0C, "R5");
    // read: gap then re-arm with last call
    read("R4");
    // read again, nothing pending
    read("R6");
    cyc1("R6");
    // call during read goes to pending
    rd_start_i = 1; cyc1("R3");
    call(8'h81, "R3");
    rd_end_i = 1; cyc1("R4");
    cyc1("R4");
    read("R6");
    // flag: fade then rx enable fall
    rx_en_i = 1; cyc1("R8");
    fade_i = 1; preamble_i = 1; cyc1("R7");
    cyc1("R8");
    rx_en_i = 0; cyc1("R9");
    cyc1("R9");
    // flag event while unread keeps pending call
    call(8'h06, "R3");
    sync_i = 1; rx_en_i = 1; cyc1("R7");
    rx_en_i = 0; cyc1("R9");
    read("R9");
    read("R6");
    // event on rd_end cycle
    call(8'h03, "R2");
    rd_start_i = 1; cyc1("R10");
    call_valid_i = 1; call_status_i = 8'h90; rd_end_i = 1; cyc1("R10");
    cyc1("R10");
    read("R6");

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      call_valid_i  = ($urandom_range(99) < 15);
      call_status_i = W'($urandom);
      fade_i        = ($urandom_range(99) < 4);
      preamble_i    = ($urandom_range(99) < 3);
      sync_i        = ($urandom_range(99) < 3);
      if ($urandom_range(99) < 10) rx_en_i = ~rx_en_i;
      rd_start_i    = ($urandom_range(99) < 10);
      rd_end_i      = m_busy && ($urandom_range(99) < 30);
      cyc1("R10");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule